// File: doc/BRIEF.md
# Prioritised Interrupt Controller, 64 Sources

The controller collects 64 interrupt source lines into a pending bitmap and combines it with an enable bitmap and a type bitmap. The type bit sends a source to the fast request output. All other sources go to the normal request output, which is gated by a programmable priority threshold. Each source has a 4-bit priority.

Software uses a 32-bit, word-addressed read/write port. Read data is registered and appears one cycle after the request. Two vector registers pick a winning source and acknowledge it: the read returns the source number and clears its pending bit. Software can also overwrite the pending bitmap directly, one 32-bit half at a time.

A change on a source line is seen through a one-cycle sample. A rising level sets the pending bit and a falling level clears it. Both request outputs are registered from the stored state.

Top module: `vec_intc`

## Requirements
- R1: After reset, the pending, enable, type, control and priority state are all zero, the mask reads 0x1F, and both request outputs are low.
- R2: Source edges and raw pending.
  - A rising edge on a sampled source line sets its pending bit, and a falling edge clears it.
  - If a vector read clears a source in the same cycle as that source rises, the bit ends cleared.
  - The raw pending bitmap reads at word 18 (bits 63:32) and word 19 (bits 31:0).
- R3: Enable and disable by number.
  - A write to word 2 sets the enable bit indexed by wdata[5:0].
  - A write to word 3 clears the enable bit indexed by wdata[5:0].
  - Both words read as 0.
- R4: Enable and type halves.
  - Words 4 and 5 read and write enable bits 63:32 and 31:0.
  - Words 6 and 7 do the same for the type bits.
  - A type bit of 1 marks a fast source.
- R5: Word 15-k (k = 0..7) holds the priorities of sources 8k..8k+7. The priority of source 8k+j sits in bits 4j+3:4j.
- R6: Normal request output.
  - A normal source is one that is pending, enabled and of type 0.
  - With the mask at 0x1F, irq_o is high when any normal source exists.
  - With any other mask, irq_o is high only when some normal source has a priority strictly greater than the mask.
  - irq_o reflects the state one cycle after that state changes.
- R7: fiq_o is high, one cycle after the state, when any source is pending, enabled and of type 1.
- R8: Reading word 16 returns the normal vector.
  - It picks the normal source with the highest priority. On a tie, the higher source number wins.
  - The data is the source number in bits 21:16 and its priority in bits 3:0.
  - The read clears that source's pending bit.
  - With no normal source, the read returns 0xFFFFFFFF.
- R9: Reading word 17 returns the fast vector.
  - It returns the lowest-numbered fast source and clears its pending bit.
  - With no fast source, the read returns 0xFFFFFFFF.
- R10: Pending overwrite and ignored writes.
  - A write to word 20 replaces pending bits 63:32, and a write to word 21 replaces bits 31:0. Both words read as 0.
  - Writes to words 16 to 19 and 22 to 25 change nothing.
- R11: Filtered pending readback.
  - Words 22 and 23 read normal pending bits 63:32 and 31:0.
  - Words 24 and 25 read fast pending bits 63:32 and 31:0.
- R12: Control and mask writes.
  - Word 0 keeps only bits 24, 22, 21, 20, 19 and 18 of a write.
  - Word 1 keeps the low 5 bits.
- R13: Special and unknown words.
  - Word 0x40 reads as 4.
  - Other unmapped words read as 0.
  - Writes to words 0x40 to 0xBF have no effect.
- R14: Read data for a request appears on rdata_o on the clock edge after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt source levels |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The arbitration is driven with several pending mixes:
- A single source below the threshold and one above it, which separates the mask gating from the plain "any pending" case.
- Two equal-priority sources, which shows how ties are broken.
- A high-priority source in the upper half, which tests ordering across the two halves.
- Several fast sources drained one at a time, which shows the lowest-first order.

A vector read is issued in the same cycle as a rising edge on the source it clears, which exercises the clear-versus-set order. Writes to read-only words and to the dropped window are each followed by readback of the state they could have touched.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int NUM_SRC   = 64;
  localparam int DATA_W    = 32;
  localparam int PRIO_W    = 4;
  localparam int MASK_W    = 5;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int HALVES    = NUM_SRC / DATA_W;
  localparam int PRIO_REGS = NUM_SRC * PRIO_W / DATA_W;

  localparam int OFF_CTRL   = 0;
  localparam int OFF_MASK   = 1;
  localparam int OFF_ENNUM  = 2;
  localparam int OFF_DISNUM = 3;
  localparam int OFF_EN_HI  = 4;
  localparam int OFF_EN_LO  = 5;
  localparam int OFF_TY_HI  = 6;
  localparam int OFF_TY_LO  = 7;
  localparam int OFF_PRIO   = 8;
  localparam int PRIO_LAST  = OFF_PRIO + PRIO_REGS - 1;
  localparam int OFF_NVEC   = 16;
  localparam int OFF_FVEC   = 17;
  localparam int OFF_RAW_HI = 18;
  localparam int OFF_RAW_LO = 19;
  localparam int OFF_FRC_HI = 20;
  localparam int OFF_FRC_LO = 21;
  localparam int OFF_NP_HI  = 22;
  localparam int OFF_NP_LO  = 23;
  localparam int OFF_FP_HI  = 24;
  localparam int OFF_FP_LO  = 25;
  localparam int OFF_MAGIC  = 64;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h017C_0000;
  localparam logic [DATA_W-1:0] MAGIC_VAL = 32'h0000_0004;
  localparam logic [DATA_W-1:0] NO_VEC    = 32'hFFFF_FFFF;
  localparam logic [MASK_W-1:0] MASK_RST  = 5'h1F;
endpackage

// File: rtl/vec_intc_pend.sv
module vec_intc_pend
  import vec_intc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [HALVES-1:0]  frc_i,
  input  logic [DATA_W-1:0]  frc_data_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] src_q, pend_q, edge_d, pend_d;

  // rise sets, fall clears, acknowledge clears last
  assign edge_d = ((pend_q | (src_i & ~src_q)) & ~(~src_i & src_q)) & ~clr_i;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign pend_d[h*DATA_W +: DATA_W] = frc_i[h] ? frc_data_i : edge_d[h*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|clr_i) && (frc_i == '0)) |=> ((pend_o & $past(clr_i)) == '0)); // R2
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb
  import vec_intc_pkg::*;
(
  input  logic [NUM_SRC-1:0]        nflags_i,
  input  logic [NUM_SRC-1:0]        fflags_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [MASK_W-1:0]         mask_i,
  output logic                      n_vld_o,
  output logic [IDX_W-1:0]          n_idx_o,
  output logic [PRIO_W-1:0]         n_prio_o,
  output logic                      n_above_o,
  output logic                      f_vld_o,
  output logic [IDX_W-1:0]          f_idx_o
);
  // ascending scan with >= leaves the highest index among equal priorities
  always_comb begin
    logic [PRIO_W-1:0] p;
    n_vld_o   = 1'b0;
    n_idx_o   = '0;
    n_prio_o  = '0;
    n_above_o = 1'b0;
    p         = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      p = prio_i[i*PRIO_W +: PRIO_W];
      if (nflags_i[i]) begin
        if (!n_vld_o || p >= n_prio_o) begin
          n_vld_o  = 1'b1;
          n_idx_o  = IDX_W'(i);
          n_prio_o = p;
        end
        if (MASK_W'(p) > mask_i) n_above_o = 1'b1;
      end
    end
  end

  always_comb begin
    f_vld_o = 1'b0;
    f_idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (fflags_i[i]) begin
        f_vld_o = 1'b1;
        f_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int PG_W = $clog2(PRIO_REGS);

  logic [NUM_SRC-1:0]        pend, en_q, ty_q, nflags, fflags, clr;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [DATA_W-1:0]         ctrl_q, rdata_q, rd_d, nvec, fvec;
  logic [MASK_W-1:0]         mask_q;
  logic [HALVES-1:0]         frc;
  logic                      n_vld, n_above, f_vld, irq_q, fiq_q;
  logic [IDX_W-1:0]          n_idx, f_idx;
  logic [PRIO_W-1:0]         n_prio;
  logic                      rd_fire, wr_fire, in_prio;
  logic [PG_W-1:0]           prio_sel;

  assign rd_fire  = req_i & ~we_i;
  assign wr_fire  = req_i & we_i;
  assign in_prio  = (addr_i >= ADDR_W'(OFF_PRIO)) && (addr_i <= ADDR_W'(PRIO_LAST));
  assign prio_sel = PG_W'(ADDR_W'(PRIO_LAST) - addr_i);

  assign nflags = pend & en_q & ~ty_q;
  assign fflags = pend & en_q & ty_q;

  vec_intc_arb u_arb (
    .nflags_i (nflags),
    .fflags_i (fflags),
    .prio_i   (prio_q),
    .mask_i   (mask_q),
    .n_vld_o  (n_vld),
    .n_idx_o  (n_idx),
    .n_prio_o (n_prio),
    .n_above_o(n_above),
    .f_vld_o  (f_vld),
    .f_idx_o  (f_idx)
  );

  always_comb begin
    nvec = NO_VEC;
    fvec = NO_VEC;
    if (n_vld) begin
      nvec = '0;
      nvec[16 +: IDX_W]    = n_idx;
      nvec[PRIO_W-1:0]     = n_prio;
    end
    if (f_vld) fvec = DATA_W'(f_idx);
  end

  // acknowledge on vector read
  always_comb begin
    clr = '0;
    if (rd_fire && addr_i == ADDR_W'(OFF_NVEC) && n_vld) clr[n_idx] = 1'b1;
    if (rd_fire && addr_i == ADDR_W'(OFF_FVEC) && f_vld) clr[f_idx] = 1'b1;
  end

  always_comb begin
    frc = '0;
    frc[HALVES-1] = wr_fire && addr_i == ADDR_W'(OFF_FRC_HI);
    frc[0]        = wr_fire && addr_i == ADDR_W'(OFF_FRC_LO);
  end

  vec_intc_pend u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_i),
    .clr_i     (clr),
    .frc_i     (frc),
    .frc_data_i(wdata_i),
    .pend_o    (pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= MASK_RST;
      en_q   <= '0;
      ty_q   <= '0;
      prio_q <= '0;
    end else if (wr_fire) begin
      case (addr_i)
        ADDR_W'(OFF_CTRL):   ctrl_q <= wdata_i & CTRL_KEEP;
        ADDR_W'(OFF_MASK):   mask_q <= wdata_i[MASK_W-1:0];
        ADDR_W'(OFF_ENNUM):  en_q[wdata_i[IDX_W-1:0]] <= 1'b1;
        ADDR_W'(OFF_DISNUM): en_q[wdata_i[IDX_W-1:0]] <= 1'b0;
        ADDR_W'(OFF_EN_HI):  en_q[DATA_W +: DATA_W] <= wdata_i;
        ADDR_W'(OFF_EN_LO):  en_q[0 +: DATA_W] <= wdata_i;
        ADDR_W'(OFF_TY_HI):  ty_q[DATA_W +: DATA_W] <= wdata_i;
        ADDR_W'(OFF_TY_LO):  ty_q[0 +: DATA_W] <= wdata_i;
        default: if (in_prio) prio_q[int'(prio_sel)*DATA_W +: DATA_W] <= wdata_i;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    case (addr_i)
      ADDR_W'(OFF_CTRL):   rd_d = ctrl_q;
      ADDR_W'(OFF_MASK):   rd_d = DATA_W'(mask_q);
      ADDR_W'(OFF_EN_HI):  rd_d = en_q[DATA_W +: DATA_W];
      ADDR_W'(OFF_EN_LO):  rd_d = en_q[0 +: DATA_W];
      ADDR_W'(OFF_TY_HI):  rd_d = ty_q[DATA_W +: DATA_W];
      ADDR_W'(OFF_TY_LO):  rd_d = ty_q[0 +: DATA_W];
      ADDR_W'(OFF_NVEC):   rd_d = nvec;
      ADDR_W'(OFF_FVEC):   rd_d = fvec;
      ADDR_W'(OFF_RAW_HI): rd_d = pend[DATA_W +: DATA_W];
      ADDR_W'(OFF_RAW_LO): rd_d = pend[0 +: DATA_W];
      ADDR_W'(OFF_NP_HI):  rd_d = nflags[DATA_W +: DATA_W];
      ADDR_W'(OFF_NP_LO):  rd_d = nflags[0 +: DATA_W];
      ADDR_W'(OFF_FP_HI):  rd_d = fflags[DATA_W +: DATA_W];
      ADDR_W'(OFF_FP_LO):  rd_d = fflags[0 +: DATA_W];
      ADDR_W'(OFF_MAGIC):  rd_d = MAGIC_VAL;
      default: if (in_prio) rd_d = prio_q[int'(prio_sel)*DATA_W +: DATA_W];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
    end else begin
      if (rd_fire) rdata_q <= rd_d;
      irq_q <= (mask_q == MASK_RST) ? (|nflags) : n_above;
      fiq_q <= |fflags;
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
  assign fiq_o   = fiq_q;

  AST_NVEC_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_vld |-> nflags[n_idx]); // R8
  AST_FVEC_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_vld |-> (fflags[f_idx] && ((fflags & ((NUM_SRC'(1) << f_idx) - NUM_SRC'(1))) == '0))); // R9
  AST_IDLE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nflags == '0) |=> !irq_o); // R6
  AST_FIQ_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fflags) |=> fiq_o); // R7
  AST_ENNUM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && addr_i == ADDR_W'(OFF_ENNUM)) |=> (rdata_o == '0)); // R3
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && addr_i == ADDR_W'(OFF_EN_LO)) |=> (rdata_o == $past(en_q[DATA_W-1:0]))); // R14
endmodule

// File: tb/vec_intc_bench.sv
module vec_intc_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_P/2) clk = ~clk;

  vec_intc u_vec_intc (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .src_i  (src),
    .req_i  (req),
    .we_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq),
    .fiq_o  (fiq)
  );

  // reference model
  logic [63:0] m_pend = '0, m_en = '0, m_typ = '0, m_srcq = '0;
  logic [31:0] m_ctrl = '0;
  logic [4:0]  m_mask = 5'h1F;
  int          m_prio [64];
  logic        exp_irq = 1'b0, exp_fiq = 1'b0;
  logic [31:0] rd_exp = '0;
  bit          rd_chk = 0;
  string       rd_tag = "", rd_tag_q = "";

  initial foreach (m_prio[i]) m_prio[i] = 0;

  task automatic model_read(input int a, output logic [31:0] d, output logic [63:0] c);
    logic [63:0] nf, ff;
    int best, who;
    nf = m_pend & m_en & ~m_typ;
    ff = m_pend & m_en & m_typ;
    c = '0;
    d = '0;
    if (a == 0) d = m_ctrl;
    else if (a == 1) d = 32'(m_mask);
    else if (a == 4) d = m_en[63:32];
    else if (a == 5) d = m_en[31:0];
    else if (a == 6) d = m_typ[63:32];
    else if (a == 7) d = m_typ[31:0];
    else if (a >= 8 && a <= 15) begin
      for (int j = 0; j < 8; j++) d = d | (32'(m_prio[(15 - a) * 8 + j]) << (4 * j));
    end else if (a == 16) begin
      best = -1; who = -1;
      for (int i = 63; i >= 0; i--)
        if (nf[i] && m_prio[i] > best) begin best = m_prio[i]; who = i; end
      if (who < 0) d = 32'hFFFF_FFFF;
      else begin d = (32'(who) << 16) | 32'(best); c[who] = 1'b1; end
    end else if (a == 17) begin
      who = -1;
      for (int i = 0; i < 64; i++) if (ff[i] && who < 0) who = i;
      if (who < 0) d = 32'hFFFF_FFFF;
      else begin d = 32'(who); c[who] = 1'b1; end
    end
    else if (a == 18) d = m_pend[63:32];
    else if (a == 19) d = m_pend[31:0];
    else if (a == 22) d = nf[63:32];
    else if (a == 23) d = nf[31:0];
    else if (a == 24) d = ff[63:32];
    else if (a == 25) d = ff[31:0];
    else if (a == 64) d = 32'd4;
  endtask

  task automatic model_write(input int a, input logic [31:0] d);
    if (a == 0) m_ctrl = d & 32'h017C_0000;
    else if (a == 1) m_mask = d[4:0];
    else if (a == 2) m_en[d[5:0]] = 1'b1;
    else if (a == 3) m_en[d[5:0]] = 1'b0;
    else if (a == 4) m_en[63:32] = d;
    else if (a == 5) m_en[31:0] = d;
    else if (a == 6) m_typ[63:32] = d;
    else if (a == 7) m_typ[31:0] = d;
    else if (a >= 8 && a <= 15) begin
      for (int j = 0; j < 8; j++) m_prio[(15 - a) * 8 + j] = int'((d >> (4 * j)) & 32'hF);
    end
    else if (a == 20) m_pend[63:32] = d;
    else if (a == 21) m_pend[31:0] = d;
  endtask

  always @(posedge clk) begin
    logic [63:0] nf, ff, c;
    logic nx_irq, nx_fiq;
    logic [31:0] d;
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_typ = '0; m_srcq = '0; m_ctrl = '0; m_mask = 5'h1F;
      foreach (m_prio[i]) m_prio[i] = 0;
      exp_irq = 1'b0; exp_fiq = 1'b0; rd_chk = 0;
    end else begin
      nf = m_pend & m_en & ~m_typ;
      ff = m_pend & m_en & m_typ;
      nx_irq = 1'b0;
      if (m_mask == 5'h1F) nx_irq = |nf;
      else for (int i = 0; i < 64; i++) if (nf[i] && m_prio[i] > int'(m_mask)) nx_irq = 1'b1;
      nx_fiq = |ff;
      c = '0;
      rd_chk = 0;
      if (req && !we) begin
        model_read(int'(addr), d, c);
        rd_exp = d; rd_chk = 1; rd_tag_q = rd_tag;
      end
      for (int i = 0; i < 64; i++) begin
        if (src[i] && !m_srcq[i]) m_pend[i] = 1'b1;
        if (!src[i] && m_srcq[i]) m_pend[i] = 1'b0;
        if (c[i]) m_pend[i] = 1'b0;
      end
      m_srcq = src;
      if (req && we) model_write(int'(addr), wdata);
      exp_irq = nx_irq;
      exp_fiq = nx_fiq;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(irq === exp_irq, "R6 irq_o", 32'(irq), 32'(exp_irq));
    chk(fiq === exp_fiq, "R7 fiq_o", 32'(fiq), 32'(exp_fiq));
    if (rd_chk) chk(rdata === rd_exp, {"R14 ", rd_tag_q}, rdata, rd_exp);
  end

  task automatic wr(input int a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = 10'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, input string t);
    req = 1'b1; we = 1'b0; addr = 10'(a); rd_tag = t;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++; n_fail++;
    $display("FAIL R14 watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset readback
    for (int a = 0; a < 26; a++) rd(a, "R1 reset");
    // R3 enable by number
    wr(2, 32'h0000_0045); wr(2, 32'd40);
    rd(5, "R3 en lo"); rd(4, "R3 en hi"); rd(2, "R3 read zero");
    wr(3, 32'd5); rd(5, "R3 disable"); rd(3, "R3 read zero");
    // R4 halves
    wr(5, 32'h0000_F00F); wr(4, 32'h8000_0081); wr(7, 32'h0000_0003); wr(6, 32'h0);
    rd(5, "R4 en lo"); rd(4, "R4 en hi"); rd(7, "R4 type lo"); rd(6, "R4 type hi");
    // R5 priorities
    wr(15, 32'h7654_3210); wr(8, 32'hF000_0000); wr(14, 32'h0000_0009);
    rd(15, "R5 grp0"); rd(8, "R5 grp7"); rd(14, "R5 grp1"); rd(11, "R5 grp4");
    // R2 / R6 edges and threshold
    src[3] = 1'b1; idle(2); rd(19, "R2 raw lo");
    wr(1, 32'd5); idle(3);
    wr(2, 32'd7); src[7] = 1'b1; idle(3);
    rd(23, "R11 normal lo");
    // R7 / R9 fast drain
    src[0] = 1'b1; src[1] = 1'b1; idle(3);
    rd(25, "R11 fast lo");
    rd(17, "R9 first"); rd(17, "R9 second"); rd(17, "R9 empty"); idle(2);
    // R8 normal vector, cross-half and ties
    src[63] = 1'b1; idle(2);
    rd(22, "R11 normal hi");
    rd(16, "R8 top");
    wr(15, 32'h0000_6600); src[2] = 1'b1; idle(2);
    rd(16, "R8 tie high"); rd(16, "R8 tie low"); rd(16, "R8 zero prio"); rd(16, "R8 empty");
    idle(2);
    // R2 acknowledge vs rise in same cycle
    wr(21, 32'h0000_4000); idle(1);
    src[14] = 1'b1; rd(16, "R2 ack");
    rd(19, "R2 ack beats rise");
    src[3] = 1'b0; idle(2); rd(19, "R2 fall clears");
    // R10 force and ignored writes
    wr(20, 32'hA5A5_0000); rd(18, "R10 force hi");
    rd(20, "R10 read zero"); rd(21, "R10 read zero");
    wr(18, 32'hFFFF_FFFF); wr(19, 32'hFFFF_FFFF); wr(16, 32'h1); wr(17, 32'h1);
    wr(22, 32'hFFFF_FFFF); wr(23, 32'hFFFF_FFFF); wr(24, 32'hFFFF_FFFF); wr(25, 32'hFFFF_FFFF);
    rd(18, "R10 ignored hi"); rd(19, "R10 ignored lo");
    rd(5, "R10 en kept"); rd(7, "R10 type kept");
    rd(24, "R11 fast hi");
    // R12 control and mask
    wr(0, 32'hFFFF_FFFF); rd(0, "R12 ctrl");
    wr(0, 32'h0200_0000); rd(0, "R12 ctrl b25");
    wr(1, 32'hFFFF_FFE3); rd(1, "R12 mask"); idle(2);
    wr(1, 32'h1F); idle(2);
    // R13 special and unknown words
    rd(64, "R13 magic"); rd(30, "R13 unknown"); rd(200, "R13 unknown");
    wr(64, 32'h1); wr(100, 32'hFFFF_FFFF); wr(191, 32'hFFFF_FFFF);
    rd(64, "R13 magic kept");
    for (int a = 0; a < 8; a++) rd(a, "R13 state kept");
    idle(4);
    finish_run();
  end
endmodule